// File: doc/BRIEF.md
# 32-Pin General-Purpose I/O Controller with Grouped Interrupts

This block gives software direct control over 32 pads through a small word-addressed register port. Every pin can be an input or an output. An output pin drives a stored value, or a shared square wave when blinking is turned on for it. Every input pin is synchronised to the clock, and a per-pin inversion bit can flip it. Software reads the result as the data-in word.

The adjusted input feeds two interrupt sources. One is level based and masked per pin. The other is edge based: a sticky cause bit records each 0-to-1 transition of the adjusted value, and a second per-pin mask gates it. The combined per-pin cause is OR-reduced into one interrupt line for each group of eight neighbouring pins.

The inversion bit selects active-high or active-low for level interrupts, and rising or falling edge for edge interrupts. Software can catch both edges by flipping the inversion bit after each event. Rewriting that bit never creates an edge of its own.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After synchronous reset, the direction word reads 0xFFFFFFFF, so every pin is an input and pad_oe is all zero. The output, blink, inversion, edge-cause, edge-mask and level-mask words read zero, and irq is zero.
- R2: Direction word at offset 0x104. A bit of 1 makes the pin an input with pad_oe low. A bit of 0 drives pad_oe high, and from the next cycle pad_out carries that pin's bit of the output word at offset 0x100.
- R3: Reading offset 0x110 returns, per pin, the pad level after a two-flop synchronizer XOR the inversion bit at offset 0x10C. A pad change made before clock edge k is visible after edge k+1.
- R4: Per pin, cause = (data-in AND level mask at 0x11C) OR (edge cause AND edge mask at 0x118). irq[g] is the OR of the cause bits of pins 8g to 8g+7.
- R5: An edge-cause bit at offset 0x114 is set one cycle after the synchronized, inversion-adjusted value goes from 0 to 1. It stays set. With inversion 0 this is a rising pad edge, and with inversion 1 a falling pad edge.
- R6: Writing the edge-cause word clears every bit written as 0 and keeps every bit written as 1. A new edge in the same cycle as a clear leaves its bit set.
- R7: Rewriting the inversion word while the pads are steady sets no edge-cause bit.
- R8: An edge is recorded in the edge-cause word even while its edge-mask bit is 0. It reaches irq only when that mask bit is 1.
- R9: For a pin whose blink bit (offset 0x108) is 1, pad_out follows a free-running square wave that is high for 2^BLINK_BIT cycles and low for 2^BLINK_BIT cycles. All blinking pins share one phase, and non-blinking pins keep following the output word.
- R10: rdata is zero whenever rd_en is low, and on reads of any offset other than the eight listed. Writes to offset 0x110 or to unlisted offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte offset of the register being accessed |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| rd_en | input | 1 | Read strobe; rdata is valid in the same cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when not reading |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Value driven towards the pads |
| pad_oe | output | 32 | Per-pin output enable, high for output pins |
| irq | output | 4 | Summary interrupts, one per group of eight pins |

## Verification
Two events can land in the same clock edge: a software write that clears the edge-cause word, and a fresh edge that wants to set a bit in it. The bench sets this up by changing a pad, then timing a write of all zeros to the cause word so that its strobe is sampled at the same edge that records the new edge. It then expects that pin's cause bit to survive while every older bit is gone. A related overlap is an inversion rewrite during steady pads, which changes data-in in the same cycle the edge detector is looking. The bench judges this by reading the cause word back unchanged.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GPIO_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFF_DOUT   = 12'h100;
    localparam logic [ADDR_W-1:0] OFF_DIR    = 12'h104;
    localparam logic [ADDR_W-1:0] OFF_BLINK  = 12'h108;
    localparam logic [ADDR_W-1:0] OFF_POL    = 12'h10C;
    localparam logic [ADDR_W-1:0] OFF_DIN    = 12'h110;
    localparam logic [ADDR_W-1:0] OFF_ECAUSE = 12'h114;
    localparam logic [ADDR_W-1:0] OFF_EMASK  = 12'h118;
    localparam logic [ADDR_W-1:0] OFF_LMASK  = 12'h11C;

    typedef enum logic [3:0] {
        SEL_DOUT,
        SEL_DIR,
        SEL_BLINK,
        SEL_POL,
        SEL_DIN,
        SEL_ECAUSE,
        SEL_EMASK,
        SEL_LMASK,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [GPIO_W-1:0] dout;
        logic [GPIO_W-1:0] dir;
        logic [GPIO_W-1:0] blink;
        logic [GPIO_W-1:0] pol;
        logic [GPIO_W-1:0] ecause;
        logic [GPIO_W-1:0] emask;
        logic [GPIO_W-1:0] lmask;
    } gpio_regs_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_DOUT:   s = SEL_DOUT;
            OFF_DIR:    s = SEL_DIR;
            OFF_BLINK:  s = SEL_BLINK;
            OFF_POL:    s = SEL_POL;
            OFF_DIN:    s = SEL_DIN;
            OFF_ECAUSE: s = SEL_ECAUSE;
            OFF_EMASK:  s = SEL_EMASK;
            OFF_LMASK:  s = SEL_LMASK;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [GPIO_W-1:0] pad_in,
    input  logic [GPIO_W-1:0] pol,
    output logic [GPIO_W-1:0] adj,
    output logic [GPIO_W-1:0] edge_vec
);
    logic [GPIO_W-1:0] meta_q;
    logic [GPIO_W-1:0] sync_q;
    logic [GPIO_W-1:0] sync_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q      <= '0;
            sync_q      <= '0;
            sync_prev_q <= '0;
        end else begin
            meta_q      <= pad_in;
            sync_q      <= meta_q;
            sync_prev_q <= sync_q;
        end
    end

    // The current inversion word is applied to both samples, so a
    // rewrite of it alone can never look like a transition (R7).
    always_comb begin
        adj      = sync_q ^ pol;
        edge_vec = adj & ~(sync_prev_q ^ pol);
    end

    // R7: steady synchronised pads yield no edge, whatever pol does
    assert_no_pol_edge_R7: assert property (@(posedge clk) disable iff (rst)
        (sync_q == sync_prev_q) |-> (edge_vec == '0));

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [GPIO_W-1:0] wdata,
    input  logic [GPIO_W-1:0] adj,
    input  logic [GPIO_W-1:0] edge_vec,
    output gpio_regs_t        regs,
    output logic [GPIO_W-1:0] rdata
);
    reg_sel_e sel;
    logic     wr_hit;

    always_comb begin
        sel    = decode_offset(addr);
        wr_hit = wr_en && (sel != SEL_NONE) && (sel != SEL_DIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.dout   <= '0;
            regs.dir    <= '1;
            regs.blink  <= '0;
            regs.pol    <= '0;
            regs.ecause <= '0;
            regs.emask  <= '0;
            regs.lmask  <= '0;
        end else begin
            if (wr_hit && sel == SEL_DOUT)  regs.dout  <= wdata;
            if (wr_hit && sel == SEL_DIR)   regs.dir   <= wdata;
            if (wr_hit && sel == SEL_BLINK) regs.blink <= wdata;
            if (wr_hit && sel == SEL_POL)   regs.pol   <= wdata;
            if (wr_hit && sel == SEL_EMASK) regs.emask <= wdata;
            if (wr_hit && sel == SEL_LMASK) regs.lmask <= wdata;
            // Write-zero-to-clear; a fresh edge wins over the clear.
            if (wr_hit && sel == SEL_ECAUSE)
                regs.ecause <= (regs.ecause & wdata) | edge_vec;
            else
                regs.ecause <= regs.ecause | edge_vec;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_DOUT:   rdata = regs.dout;
                SEL_DIR:    rdata = regs.dir;
                SEL_BLINK:  rdata = regs.blink;
                SEL_POL:    rdata = regs.pol;
                SEL_DIN:    rdata = adj;
                SEL_ECAUSE: rdata = regs.ecause;
                SEL_EMASK:  rdata = regs.emask;
                SEL_LMASK:  rdata = regs.lmask;
                default:    rdata = '0;
            endcase
        end
    end

    // R5: every detected edge is present in the cause word one cycle later
    assert_edge_recorded_R5: assert property (@(posedge clk) disable iff (rst)
        (edge_vec != '0) |=> (($past(edge_vec) & ~regs.ecause) == '0));

    // R6: cause bits only fall through a write to the cause word
    assert_cause_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == OFF_ECAUSE) |=> (($past(regs.ecause) & ~regs.ecause) == '0));

endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
    parameter int BLINK_BIT = 22
) (
    input  logic clk,
    input  logic rst,
    output logic phase
);
    localparam int CNT_W = BLINK_BIT + 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign phase = cnt_q[BLINK_BIT];

endmodule

// File: rtl/gpio_irq_reduce.sv
module gpio_irq_reduce #(
    parameter int W          = 32,
    parameter int GROUP_PINS = 8,
    localparam int NGROUPS   = W / GROUP_PINS
) (
    input  logic [W-1:0]       cause,
    output logic [NGROUPS-1:0] irq
);
    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        assign irq[g] = |cause[g*GROUP_PINS +: GROUP_PINS];
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_pkg::*;
#(
    parameter int GROUP_PINS = 8,
    parameter int BLINK_BIT  = 22,
    localparam int NGROUPS   = GPIO_W / GROUP_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [GPIO_W-1:0] wdata,
    output logic [GPIO_W-1:0] rdata,
    input  logic [GPIO_W-1:0] pad_in,
    output logic [GPIO_W-1:0] pad_out,
    output logic [GPIO_W-1:0] pad_oe,
    output logic [NGROUPS-1:0] irq
);
    gpio_regs_t        regs;
    logic [GPIO_W-1:0] adj;
    logic [GPIO_W-1:0] edge_vec;
    logic [GPIO_W-1:0] cause;
    logic              blink_phase;

    gpio_in_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .pad_in   (pad_in),
        .pol      (regs.pol),
        .adj      (adj),
        .edge_vec (edge_vec)
    );

    gpio_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .adj      (adj),
        .edge_vec (edge_vec),
        .regs     (regs),
        .rdata    (rdata)
    );

    gpio_blink_gen #(.BLINK_BIT(BLINK_BIT)) u_blink (
        .clk   (clk),
        .rst   (rst),
        .phase (blink_phase)
    );

    always_comb begin
        pad_oe  = ~regs.dir;
        pad_out = (regs.dout & ~regs.blink) | ({GPIO_W{blink_phase}} & regs.blink);
        cause   = (adj & regs.lmask) | (regs.ecause & regs.emask);
    end

    gpio_irq_reduce #(.W(GPIO_W), .GROUP_PINS(GROUP_PINS)) u_reduce (
        .cause (cause),
        .irq   (irq)
    );

    // R2: a direction write shows up inverted on pad_oe one cycle later
    assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_DIR) |=> (pad_oe == ~$past(wdata)));

    // R4: with both masks clear no summary interrupt may be raised
    assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (regs.lmask == '0 && regs.emask == '0) |-> (irq == '0));

    // R9: all blinking pins carry the same level
    assert_blink_shared_R9: assert property (@(posedge clk) disable iff (rst)
        ((pad_out & regs.blink) == '0) || ((pad_out & regs.blink) == regs.blink));

endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
    import gpio_pkg::*;

    localparam int BB = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [3:0]  irq;

    int n_tests = 0;
    int n_fail  = 0;

    gpio_irq_ctrl #(.GROUP_PINS(8), .BLINK_BIT(BB)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    function automatic logic [3:0] grp_or(input logic [31:0] c);
        logic [3:0] r;
        for (int g = 0; g < 4; g++) r[g] = |c[g*8 +: 8];
        return r;
    endfunction

    // bench model state
    logic [31:0] m_pol, m_lm, m_em, m_cause, m_pad;

    task automatic check_all(input string tag);
        logic [31:0] v;
        logic [31:0] adjv;
        adjv = m_pad ^ m_pol;
        rd(OFF_DIN, v);    chk({tag, " R3 data-in"}, v, adjv);
        rd(OFF_ECAUSE, v); chk({tag, " R5 edge cause"}, v, m_cause);
        chk({tag, " R4 irq"}, {28'd0, irq}, {28'd0, grp_or((adjv & m_lm) | (m_cause & m_em))});
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] prev, smp, s0;
        int trans;
        logic okeq;
        void'($urandom(32'd20240611));
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd(OFF_DIR, v);    chk("R1 dir reset", v, 32'hFFFF_FFFF);
        rd(OFF_DOUT, v);   chk("R1 dout reset", v, 0);
        rd(OFF_BLINK, v);  chk("R1 blink reset", v, 0);
        rd(OFF_POL, v);    chk("R1 pol reset", v, 0);
        rd(OFF_ECAUSE, v); chk("R1 cause reset", v, 0);
        rd(OFF_EMASK, v);  chk("R1 emask reset", v, 0);
        rd(OFF_LMASK, v);  chk("R1 lmask reset", v, 0);
        chk("R1 oe reset", pad_oe, 0);
        chk("R1 irq reset", {28'd0, irq}, 0);

        // R2 direction and output value
        wr(OFF_DOUT, 32'hA5A5_0F0F);
        wr(OFF_DIR, 32'hFFFF_0000);
        chk("R2 oe", pad_oe, 32'h0000_FFFF);
        chk("R2 pad_out", pad_out & pad_oe, 32'h0000_0F0F);
        rd(OFF_DOUT, v); chk("R2 dout readback", v, 32'hA5A5_0F0F);

        // R3 latency: visible after edge k+1, not after edge k
        pad_in = 32'h0000_0100;
        @(posedge clk); @(negedge clk);
        rd(OFF_DIN, v); chk("R3 not yet after one edge", v, 0);
        @(posedge clk); @(negedge clk);
        rd(OFF_DIN, v); chk("R3 visible after two edges", v, 32'h0000_0100);
        idle(2);
        wr(OFF_ECAUSE, 32'h0);
        rd(OFF_ECAUSE, v); chk("R6 clear all", v, 0);

        // R8 edge recorded while masked, irq only when unmasked
        pad_in = 32'h0000_0300;
        idle(4);
        rd(OFF_ECAUSE, v); chk("R8 masked edge recorded", v, 32'h0000_0200);
        chk("R8 masked no irq", {28'd0, irq}, 0);
        wr(OFF_EMASK, 32'h0000_0200);
        chk("R8 unmasked irq", {28'd0, irq}, 4'b0010);
        wr(OFF_EMASK, 0);

        // R5 falling edge via polarity 1; R7 polarity write makes no edge
        wr(OFF_ECAUSE, 0);
        wr(OFF_POL, 32'h0000_0200);
        idle(3);
        rd(OFF_ECAUSE, v); chk("R7 pol write no edge", v, 0);
        pad_in = 32'h0000_0100;
        idle(4);
        rd(OFF_ECAUSE, v); chk("R5 falling edge with pol=1", v, 32'h0000_0200);

        // R6 clear coincident with fresh edge: new bit survives
        wr(OFF_POL, 0);
        pad_in = 32'h0000_0100 | 32'h0001_0000;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        wr(OFF_ECAUSE, 32'h0);
        rd(OFF_ECAUSE, v); chk("R6 edge beats clear", v, 32'h0001_0000);
        wr(OFF_ECAUSE, 32'hFFFF_FFFF);
        rd(OFF_ECAUSE, v); chk("R6 write one keeps", v, 32'h0001_0000);

        // R10 unmapped / read-only / rd_en low
        rd(12'h120, v); chk("R10 unmapped read", v, 0);
        rd(12'h000, v); chk("R10 unmapped read low", v, 0);
        addr = OFF_DIR; #1 chk("R10 rd_en low", rdata, 0);
        wr(OFF_DIN, 32'hFFFF_FFFF);
        wr(12'h124, 32'hFFFF_FFFF);
        rd(OFF_DOUT, v);  chk("R10 dout untouched", v, 32'hA5A5_0F0F);
        rd(OFF_DIR, v);   chk("R10 dir untouched", v, 32'hFFFF_0000);
        rd(OFF_POL, v);   chk("R10 pol untouched", v, 0);
        rd(OFF_LMASK, v); chk("R10 lmask untouched", v, 0);

        // R9 blink: shared phase, half period 2^BB cycles
        wr(OFF_DIR, 0);
        wr(OFF_DOUT, 32'h0000_00F0);
        wr(OFF_BLINK, 32'h8001_0001);
        s0 = pad_out; prev = s0; trans = 0; okeq = 1'b1;
        for (int i = 0; i < 2 ** (BB + 1); i++) begin
            @(posedge clk); @(negedge clk);
            smp = pad_out;
            if ((smp & 32'h8001_0001) != 0 && (smp & 32'h8001_0001) != 32'h8001_0001) okeq = 1'b0;
            if (smp[0] != prev[0]) trans++;
            if ((smp & ~32'h8001_0001) != 32'h0000_00F0) okeq = 1'b0;
            prev = smp;
        end
        chk("R9 shared phase and plain pins", {31'd0, okeq}, 1);
        chk("R9 two toggles per period", trans, 2);
        wr(OFF_BLINK, 0);
        chk("R9 blink off follows dout", pad_out, 32'h0000_00F0);

        // Random phase: R3 R4 R5 R7 against bench model
        wr(OFF_DIR, 32'hFFFF_FFFF);
        wr(OFF_ECAUSE, 0);
        m_pol = 0; m_lm = 0; m_em = 0; m_cause = 0; m_pad = pad_in;
        idle(3);
        rd(OFF_ECAUSE, m_cause);
        for (int it = 0; it < 40; it++) begin
            logic [31:0] np, old_adj, new_adj, r;
            r = $urandom;
            if (r[0]) begin m_pol = $urandom; wr(OFF_POL, m_pol); end
            if (r[1]) begin m_lm = $urandom & $urandom; wr(OFF_LMASK, m_lm); end
            if (r[2]) begin m_em = $urandom; wr(OFF_EMASK, m_em); end
            if (r[3]) begin v = $urandom; wr(OFF_ECAUSE, v); m_cause &= v; end
            idle(2);
            check_all("rand-steady R7");
            old_adj = m_pad ^ m_pol;
            np = $urandom;
            pad_in = np; m_pad = np;
            new_adj = m_pad ^ m_pol;
            m_cause |= new_adj & ~old_adj;
            idle(4);
            check_all("rand-edge");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule